// File: doc/BRIEF.md
# Pipelined Fixed-Point Multiply-Accumulate Unit

This block is the arithmetic core of a convolution engine. Each cycle it may take one operation made of two 32-bit operands, an opcode, a signedness flag and a readout selection. The operands are widened to the 48-bit internal width, either by sign extension or by zero extension. They are multiplied and the product is folded into a 48-bit accumulator. The operation then leaves the pipeline as a 32-bit result, taken from the accumulator value that this operation produced.

The pipeline has five register stages: operand capture, multiply, product register, accumulate and readout. The accumulator is updated in the fourth stage, so a chain of dependent accumulations runs at full rate with no stall. The readout stage narrows the 48-bit value to 32 bits. It can cut off the upper bits, clamp to the 32-bit range, or shift right with round-half-up and then clamp.

The input side is a valid-only stream with no back-pressure: the unit accepts every cycle, so it has no ready output. A result is presented for exactly one cycle with `out_valid`. The consumer must take it in that cycle, because results are not held back.

Top module: `mac48_unit`

## Requirements
- R1: When `in_signed` is 1, both operands are sign-extended to 48 bits; when it is 0, both are zero-extended. The product used by the unit is the low 48 bits of the product of the two extended operands.
- R2: The unit accepts one operation in every cycle, so back-to-back dependent operations each see the accumulator left by the operation before them.
- R3: The accumulator changes only for an operation with `in_valid` = 1 and an opcode other than HOLD (3). Cycles with `in_valid` = 0 leave it unchanged, whatever the other inputs hold.
- R4: Opcode MAC (0) adds the product to the accumulator, modulo 2^48.
- R5: Opcode CLEAR (1) discards the old accumulator and stores the operation's product as the new value.
- R6: Opcode LOAD (2) stores operand `in_a`, extended per R1, into the accumulator; `in_b` is ignored.
- R7: Readout mode 0 or 3 (truncate) returns bits 31..0 of the accumulator.
- R8: Readout mode 1 (saturate) clamps the accumulator to 32 bits. A signed operation clamps to the range -2^31..2^31-1, taking the accumulator as a signed 48-bit value. An unsigned operation clamps to 0..2^32-1, taking it as unsigned.
- R9: Readout mode 2 (round) adds 2^(s-1) to the accumulator, shifts it right by s = `rd_shift`, and then saturates as in R8. The shift is arithmetic for a signed operation and logical for an unsigned one. With s = 0 the result equals mode 1.
- R10: `out_valid` is high in the fifth cycle after a valid operation is presented, and only then. `out_data` carries the readout of the accumulator as that operation left it.
- R11: While `rst_n` is low, the accumulator and `out_data` are 0 and `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation present this cycle |
| in_op | input | 2 | 0 MAC, 1 CLEAR, 2 LOAD, 3 HOLD |
| in_signed | input | 1 | 1 signed operands and readout, 0 unsigned |
| rd_mode | input | 2 | 0/3 truncate, 1 saturate, 2 round |
| rd_shift | input | 5 | Right shift for round mode |
| in_a | input | 32 | First operand |
| in_b | input | 32 | Second operand |
| out_valid | output | 1 | Result present, one cycle per operation |
| out_data | output | 32 | 32-bit readout |

## Verification
Directed sequences come first. Small signed and unsigned products separate sign extension from zero extension. Operands of 0xFFFFFFFF separate the low-48-bit product from a wider one. Accumulations past 2^31 and below -2^31 separate clamping from truncation. Rounding at odd shifts on positive and negative values separates the half-up arithmetic shift from plain truncation. Bubbles that carry LOAD opcodes, followed by a HOLD readout, show that an invalid cycle leaves the accumulator alone. A long run of random back-to-back operations with mixed opcodes, signedness, modes and gaps is then compared every cycle against a behavioural model. This run exposes any stall, any reordering and any off-by-one in the result latency.

// File: rtl/mac48_pkg.sv
package mac48_pkg;

  localparam int unsigned SHW = 5;

  typedef enum logic [1:0] {
    OP_MAC   = 2'd0,
    OP_CLEAR = 2'd1,
    OP_LOAD  = 2'd2,
    OP_HOLD  = 2'd3
  } mac_op_e;

  typedef enum logic [1:0] {
    RD_TRUNC  = 2'd0,
    RD_SAT    = 2'd1,
    RD_ROUND  = 2'd2,
    RD_TRUNC3 = 2'd3
  } rd_mode_e;

  typedef struct packed {
    logic           vld;
    mac_op_e        op;
    logic           sgn;
    rd_mode_e       mode;
    logic [SHW-1:0] sh;
  } mac_ctl_t;

endpackage

// File: rtl/mac48_mul.sv
module mac48_mul
  import mac48_pkg::*;
#(
  parameter int unsigned OPW  = 32,
  parameter int unsigned ACCW = 48
) (
  input  logic            clk,
  input  logic            rst_n,
  input  mac_ctl_t        ctl_i,
  input  logic [OPW-1:0]  a_i,
  input  logic [OPW-1:0]  b_i,
  output mac_ctl_t        ctl_o,
  output logic [ACCW-1:0] prod_o,
  output logic [ACCW-1:0] lda_o
);
  localparam int unsigned XW = ACCW - OPW;
  localparam int unsigned NST = 3;

  mac_ctl_t        ctl_q [NST];
  logic [ACCW-1:0] ax_q, bx_q;
  logic [ACCW-1:0] prod2_q, lda2_q, prod3_q, lda3_q;

  // control travels beside the data through the three arithmetic stages
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NST; i++) ctl_q[i] <= '0;
    end else begin
      ctl_q[0] <= ctl_i;
      for (int i = 1; i < NST; i++) ctl_q[i] <= ctl_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ax_q    <= '0;
      bx_q    <= '0;
      prod2_q <= '0;
      lda2_q  <= '0;
      prod3_q <= '0;
      lda3_q  <= '0;
    end else begin
      // stage 1: widen operands by the operation's signedness
      ax_q    <= {{XW{ctl_i.sgn & a_i[OPW-1]}}, a_i};
      bx_q    <= {{XW{ctl_i.sgn & b_i[OPW-1]}}, b_i};
      // stage 2: multiply at accumulator width (low bits are exact)
      prod2_q <= ax_q * bx_q;
      lda2_q  <= ax_q;
      // stage 3: product register
      prod3_q <= prod2_q;
      lda3_q  <= lda2_q;
    end
  end

  assign ctl_o  = ctl_q[NST-1];
  assign prod_o = prod3_q;
  assign lda_o  = lda3_q;

endmodule

// File: rtl/mac48_acc.sv
module mac48_acc
  import mac48_pkg::*;
#(
  parameter int unsigned ACCW = 48
) (
  input  logic            clk,
  input  logic            rst_n,
  input  mac_ctl_t        ctl_i,
  input  logic [ACCW-1:0] prod_i,
  input  logic [ACCW-1:0] lda_i,
  output mac_ctl_t        ctl_o,
  output logic [ACCW-1:0] acc_o
);
  mac_ctl_t        ctl_q;
  logic [ACCW-1:0] acc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
      acc_q <= '0;
    end else begin
      ctl_q <= ctl_i;
      if (ctl_i.vld) begin
        unique case (ctl_i.op)
          OP_MAC:   acc_q <= acc_q + prod_i;
          OP_CLEAR: acc_q <= prod_i;
          OP_LOAD:  acc_q <= lda_i;
          default:  acc_q <= acc_q;
        endcase
      end
    end
  end

  assign ctl_o = ctl_q;
  assign acc_o = acc_q;

endmodule

// File: rtl/mac48_rdo.sv
module mac48_rdo
  import mac48_pkg::*;
#(
  parameter int unsigned OPW  = 32,
  parameter int unsigned ACCW = 48
) (
  input  logic            clk,
  input  logic            rst_n,
  input  mac_ctl_t        ctl_i,
  input  logic [ACCW-1:0] acc_i,
  output logic            vld_o,
  output logic [OPW-1:0]  res_o
);
  localparam int unsigned W = ACCW + 2;

  logic [W-1:0]   base, half, sum, shd, v;
  logic           fits_s, fits_u;
  logic [OPW-1:0] sat_s, sat_u, res_d;

  always_comb begin
    base = {{2{ctl_i.sgn & acc_i[ACCW-1]}}, acc_i};
    half = '0;
    if (ctl_i.sh != '0) half = W'(1) << (ctl_i.sh - SHW'(1));
    sum  = base + half;
    shd  = W'($signed(sum) >>> ctl_i.sh);
    v    = (ctl_i.mode == RD_ROUND) ? shd : base;

    fits_s = (&v[W-1:OPW-1]) | ~(|v[W-1:OPW-1]);
    sat_s  = fits_s ? v[OPW-1:0]
                    : (v[W-1] ? {1'b1, {(OPW-1){1'b0}}} : {1'b0, {(OPW-1){1'b1}}});
    fits_u = ~(|v[W-1:OPW]);
    sat_u  = fits_u ? v[OPW-1:0] : '1;

    if (ctl_i.mode == RD_TRUNC || ctl_i.mode == RD_TRUNC3) res_d = acc_i[OPW-1:0];
    else if (ctl_i.sgn)                                    res_d = sat_s;
    else                                                   res_d = sat_u;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_o <= 1'b0;
      res_o <= '0;
    end else begin
      vld_o <= ctl_i.vld;
      res_o <= res_d;
    end
  end

endmodule

// File: rtl/mac48_unit.sv
module mac48_unit
  import mac48_pkg::*;
#(
  parameter int unsigned OPW  = 32,
  parameter int unsigned ACCW = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [1:0]       in_op,
  input  logic             in_signed,
  input  logic [1:0]       rd_mode,
  input  logic [SHW-1:0]   rd_shift,
  input  logic [OPW-1:0]   in_a,
  input  logic [OPW-1:0]   in_b,
  output logic             out_valid,
  output logic [OPW-1:0]   out_data
);
  mac_ctl_t        in_ctl, s3_ctl, s4_ctl;
  logic [ACCW-1:0] s3_prod, s3_lda, acc_val;

  assign in_ctl = '{vld: in_valid, op: mac_op_e'(in_op), sgn: in_signed,
                    mode: rd_mode_e'(rd_mode), sh: rd_shift};

  mac48_mul #(.OPW(OPW), .ACCW(ACCW)) u_mul (
    .clk(clk), .rst_n(rst_n), .ctl_i(in_ctl), .a_i(in_a), .b_i(in_b),
    .ctl_o(s3_ctl), .prod_o(s3_prod), .lda_o(s3_lda)
  );

  mac48_acc #(.ACCW(ACCW)) u_acc (
    .clk(clk), .rst_n(rst_n), .ctl_i(s3_ctl), .prod_i(s3_prod), .lda_i(s3_lda),
    .ctl_o(s4_ctl), .acc_o(acc_val)
  );

  mac48_rdo #(.OPW(OPW), .ACCW(ACCW)) u_rdo (
    .clk(clk), .rst_n(rst_n), .ctl_i(s4_ctl), .acc_i(acc_val),
    .vld_o(out_valid), .res_o(out_data)
  );

endmodule

// File: rtl/mac48_chk.sv
module mac48_chk #(
  parameter int unsigned ACCW = 48
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            out_valid,
  input logic            acc_vld,
  input logic [1:0]      acc_op,
  input logic [ACCW-1:0] prod,
  input logic [ACCW-1:0] lda,
  input logic [ACCW-1:0] acc
);
  logic [4:0] hist;
  logic [2:0] seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist <= '0;
      seen <= '0;
    end else begin
      hist <= {hist[3:0], in_valid};
      if (seen != 3'd5) seen <= seen + 3'd1;
    end
  end

  // R10: result flag trails the accepted operation by five edges
  a_r10_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (seen == 3'd5) |-> (out_valid == hist[4]));

  // R3: no update without a valid non-hold operation
  a_r3_acc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_vld || acc_op == 2'd3) |=> $stable(acc));

  // R4: accumulate adds the product
  a_r4_mac_add: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_vld && acc_op == 2'd0) |=> (acc == ACCW'($past(acc) + $past(prod))));

  // R5: clear replaces the accumulator with the product
  a_r5_clear_prod: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_vld && acc_op == 2'd1) |=> (acc == $past(prod)));

  // R6: load takes the widened first operand
  a_r6_load_operand: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_vld && acc_op == 2'd2) |=> (acc == $past(lda)));

endmodule

bind mac48_unit mac48_chk #(.ACCW(ACCW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_valid(out_valid),
  .acc_vld(s3_ctl.vld), .acc_op(s3_ctl.op), .prod(s3_prod), .lda(s3_lda),
  .acc(acc_val)
);

// File: tb/test_mac48_unit.sv
module test_mac48_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  in_op = 2'd0;
  logic        in_signed = 1'b0;
  logic [1:0]  rd_mode = 2'd0;
  logic [4:0]  rd_shift = 5'd0;
  logic [31:0] in_a = '0;
  logic [31:0] in_b = '0;
  logic        out_valid;
  logic [31:0] out_data;

  int checks = 0;
  int fails  = 0;

  // model state
  logic [47:0] m_acc = '0;
  logic        q_v [5];
  logic [31:0] q_d [5];
  string       q_t [5];

  always #10 clk = ~clk;

  mac48_unit i_mac48_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .in_signed(in_signed), .rd_mode(rd_mode), .rd_shift(rd_shift),
    .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_data(out_data)
  );

  function automatic longint widen(logic [31:0] x, bit sg);
    return sg ? longint'($signed(x)) : longint'({32'b0, x});
  endfunction

  function automatic logic [31:0] readout(logic [47:0] acc, bit sg, logic [1:0] md, logic [4:0] sh);
    longint v;
    if (md == 2'd0 || md == 2'd3) return acc[31:0];
    v = sg ? longint'($signed(acc)) : longint'({16'b0, acc});
    if (md == 2'd2 && sh != 0) v = (v + (longint'(1) << (sh - 1))) >>> sh;
    if (sg) begin
      if (v > 64'sd2147483647)  return 32'h7FFF_FFFF;
      if (v < -64'sd2147483648) return 32'h8000_0000;
    end else begin
      if (v > 64'sd4294967295)  return 32'hFFFF_FFFF;
    end
    return v[31:0];
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic issue(bit v, logic [1:0] op, bit sg, logic [1:0] md, logic [4:0] sh,
                       logic [31:0] a, logic [31:0] b, string tag);
    longint p;
    logic [31:0] e = '0;
    in_valid = v; in_op = op; in_signed = sg; rd_mode = md; rd_shift = sh;
    in_a = a; in_b = b;
    if (v) begin
      p = widen(a, sg) * widen(b, sg);
      case (op)
        2'd0: m_acc = m_acc + p[47:0];
        2'd1: m_acc = p[47:0];
        2'd2: m_acc = 48'(widen(a, sg));
        default: ;
      endcase
      e = readout(m_acc, sg, md, sh);
    end
    for (int i = 4; i > 0; i--) begin
      q_v[i] = q_v[i-1]; q_d[i] = q_d[i-1]; q_t[i] = q_t[i-1];
    end
    q_v[0] = v; q_d[0] = e; q_t[0] = tag;
    @(posedge clk);
    @(negedge clk);
    check("R10 valid timing", {31'b0, out_valid}, {31'b0, q_v[4]});
    if (q_v[4]) check(q_t[4], out_data, q_d[4]);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    for (int i = 0; i < 5; i++) begin q_v[i] = 1'b0; q_d[i] = '0; q_t[i] = ""; end
    repeat (3) @(negedge clk);
    check("R11 reset valid", {31'b0, out_valid}, 32'd0);
    check("R11 reset data", out_data, 32'd0);
    rst_n = 1'b1;

    issue(1, 2'd3, 1, 2'd0, 0, 32'd0, 32'd0, "R11 acc zero");
    issue(1, 2'd2, 1, 2'd0, 0, 32'hFFFF_FFFB, 32'h1234, "R6 load signed");
    issue(1, 2'd0, 1, 2'd0, 0, 32'd3, 32'hFFFF_FFFC, "R4 R1 signed mac");
    issue(1, 2'd0, 0, 2'd0, 0, 32'hFFFF_FFFF, 32'd2, "R1 unsigned mac");
    issue(1, 2'd3, 1, 2'd1, 0, 32'd0, 32'd0, "R8 signed sat of mixed sum");
    issue(1, 2'd1, 1, 2'd0, 0, 32'd7, 32'd6, "R5 clear");
    issue(1, 2'd0, 1, 2'd1, 0, 32'h7FFF_FFFF, 32'h7FFF_FFFF, "R8 sat high");
    issue(1, 2'd0, 1, 2'd0, 0, 32'h7FFF_FFFF, 32'h7FFF_FFFF, "R7 trunc");
    issue(1, 2'd3, 1, 2'd3, 0, 32'd0, 32'd0, "R7 trunc mode 3");
    issue(1, 2'd1, 1, 2'd1, 0, 32'h8000_0001, 32'h0004_0000, "R8 sat low");
    issue(1, 2'd1, 0, 2'd1, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R8 unsigned sat");
    issue(1, 2'd3, 0, 2'd0, 0, 32'd0, 32'd0, "R1 unsigned product low 48");
    issue(1, 2'd2, 0, 2'd1, 0, 32'h8000_0000, 32'd9, "R6 load unsigned");
    issue(1, 2'd1, 1, 2'd2, 3, 32'd100, 32'd1, "R9 round positive");
    issue(1, 2'd1, 1, 2'd2, 3, 32'hFFFF_FF9C, 32'd1, "R9 round negative");
    issue(1, 2'd1, 1, 2'd2, 1, 32'd5, 32'd1, "R9 round half up");
    issue(1, 2'd1, 1, 2'd2, 0, 32'h7FFF_FFFF, 32'd16, "R9 shift zero saturates");
    issue(1, 2'd1, 1, 2'd2, 16, 32'h7FFF_FFFF, 32'h7FFF_FFFF, "R9 round large");
    issue(1, 2'd1, 0, 2'd2, 8, 32'hFFFF_FFFF, 32'h0000_0300, "R9 round unsigned");
    issue(1, 2'd2, 1, 2'd0, 0, 32'd42, 32'd0, "R6 load before bubbles");
    for (int i = 0; i < 6; i++)
      issue(0, 2'd2, 1, 2'd0, 0, 32'hDEAD_0000 + i, 32'd1, "R3 bubble");
    issue(1, 2'd3, 1, 2'd0, 0, 32'd0, 32'd0, "R3 acc unchanged by bubbles");

    for (int i = 0; i < 400; i++) begin
      automatic bit v = (i < 200) ? 1'b1 : ($urandom_range(0, 3) != 0);
      issue(v, 2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
            2'($urandom_range(0, 3)), 5'($urandom_range(0, 31)),
            $urandom(), (i % 3 == 0) ? $urandom() : 32'($urandom_range(0, 70000)),
            "R2 back-to-back random");
    end
    for (int i = 0; i < 6; i++) issue(0, 2'd0, 0, 2'd0, 0, 32'd0, 32'd0, "R10 drain");
    summary();
  end

endmodule